// File: doc/BRIEF.md
# Serial Receiver Register Front End

This block sits between a byte-wide register bus and a serial receiver. It holds the baud divisor that the receiver uses and keeps the bytes the receiver delivers, each tagged with a framing/parity error flag, in a small first-in first-out buffer. Software programs the divisor, polls a status register to learn whether a byte is waiting and whether that byte arrived with an error, then reads the byte. The read itself removes the byte from the buffer.

The bus is an 8-bit path with a 4-bit byte address and separate single-cycle read and write strobes. Read data is combinational and is valid in the same cycle as the read strobe. The divisor is wider than the bus. Software updates it through a staging buffer and a commit byte, so the receiver never sees a half-written value. Software reads it back through a snapshot taken when the lowest byte is read. On the receiver side, bytes arrive with a valid/ready handshake, and the receiver is told it may deliver only while the buffer has room.

Top module: `serial_rx_regs`

## Requirements
- R1: After reset, `baud_div` equals the parameter `DIV_RESET`, the status register reads 0x00 and `rx_ready` is 1.
- R2: The divisor is readable at offsets 0, 1 and 2 as bytes 0 (bits 7:0), 1 and 2, least significant first. Bits above `DIV_W` read as zero. `csr_rdata` is valid in the same cycle as `csr_rd`.
- R3: Writes to offsets 0 and 1 fill a staging buffer and leave `baud_div` unchanged. A write to offset 2 loads all three bytes (staged bytes 0 and 1, plus the written byte 2) into the divisor, and `baud_div` shows the new value in the cycle after the strobe.
- R4: A read of offset 0 returns the live divisor byte 0 and captures the whole divisor. Reads of offsets 1 and 2 return bytes of that capture, even if the divisor has since changed.
- R5: The status register at offset 3 reports the buffer not being empty in bit 0 and the error flag of the oldest stored byte in bit 4. All other bits read zero. Writes to offset 3 have no effect.
- R6: The data register at offset 4 returns the oldest stored byte. A read strobe on offset 4 removes that entry, so the next read returns the following byte in arrival order.
- R7: The buffer holds 16 entries. `rx_ready` is 1 exactly when the buffer is not full. A byte and its error flag are stored on a clock edge where `rx_valid` and `rx_ready` are both 1. A byte offered while `rx_ready` is 0 is not stored.
- R8: A read of offset 4 while the buffer is empty returns 0x00 and removes nothing. A byte that arrives later is the next byte read.
- R9: Offsets 5 to 15 read as 0x00. Writes to them, and to offset 4, change neither the divisor nor the stored bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Byte address of the register access |
| csr_rd | input | 1 | Read strobe, one cycle per access |
| csr_wr | input | 1 | Write strobe, one cycle per access |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, combinational from the address |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Error flag of the offered byte |
| rx_ready | output | 1 | Buffer has room; the offered byte is taken |
| baud_div | output | DIV_W | Committed divisor value for the receiver |

## Verification
The cycle-by-cycle checks cover these rules: the divisor holds still unless offset 2 was written in the previous cycle, the top divisor byte follows the commit write, reserved status bits and unmapped offsets read zero, an empty data read returns zero, and `rx_ready` is high whenever the buffer is empty. Only the bench scenarios can show the behaviour that depends on history: staging followed by commit of the full value, snapshot consistency across an intervening commit, arrival-order return of bytes with their error flags, refusal at sixteen entries, and the fact that an empty read removes nothing.

// File: rtl/srx_regs_pkg.sv
`timescale 1ns/1ps
package srx_regs_pkg;
   // One buffered receive entry: error flag above the byte.
   typedef struct packed {
      logic       err;
      logic [7:0] data;
   } rx_entry_t;

   // Byte offsets that the decode depends on.
   localparam int unsigned OFS_DIV_B0 = 0;
   localparam int unsigned OFS_DIV_B1 = 1;
   localparam int unsigned OFS_DIV_B2 = 2;
   localparam int unsigned OFS_STATUS = 3;
   localparam int unsigned OFS_RXDATA = 4;

   // Status bit positions.
   localparam int unsigned STS_NONEMPTY = 0;
   localparam int unsigned STS_HEAD_ERR = 4;

   // Widest divisor the three divisor bytes can hold.
   localparam int unsigned DIV_MAX_W = 24;
endpackage

// File: rtl/srx_fifo.sv
`timescale 1ns/1ps
module srx_fifo
   import srx_regs_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  rx_entry_t push_entry,
   input  logic      pop,
   output rx_entry_t head,
   output logic      empty,
   output logic      full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("srx_fifo: DEPTH must be a power of two of at least 2");
   end

   rx_entry_t        store [DEPTH];
   logic [PTR_W:0]   wr_ptr;
   logic [PTR_W:0]   rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr[PTR_W-1:0]] <= push_entry;
   end

   assign head  = store[rd_ptr[PTR_W-1:0]];
   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                  (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
endmodule

// File: rtl/srx_divisor.sv
`timescale 1ns/1ps
module srx_divisor
   import srx_regs_pkg::*;
#(
   parameter int unsigned DIV_W     = 24,
   parameter int unsigned DIV_RESET = 868
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [7:0]       wdata,
   input  logic             snap_en,
   input  logic [1:0]       rd_sel,
   output logic [7:0]       rdata,
   output logic [DIV_W-1:0] div_out
);
   localparam int unsigned PAD_W = DIV_MAX_W - DIV_W;

   if (DIV_W < 1 || DIV_W > DIV_MAX_W) begin : g_bad_width
      $error("srx_divisor: DIV_W must lie in 1..24");
   end
   if (DIV_W < 32 && (DIV_RESET >> DIV_W) != 0) begin : g_bad_reset
      $error("srx_divisor: DIV_RESET does not fit in DIV_W bits");
   end

   logic [15:0]          staged;
   logic [DIV_W-1:0]     div_q;
   logic [DIV_MAX_W-1:0] div_wide;
   logic [DIV_MAX_W-1:0] snap_q;
   logic [DIV_MAX_W-1:0] commit_val;

   // Zero-extend the stored divisor to the full three-byte view.
   if (PAD_W == 0) begin : g_full
      assign div_wide = div_q;
   end else begin : g_padded
      assign div_wide = {{PAD_W{1'b0}}, div_q};
   end

   assign commit_val = {wdata, staged};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '0;
         div_q  <= DIV_W'(DIV_RESET);
         snap_q <= '0;
      end else begin
         if (wr_en) begin
            unique case (wr_sel)
               2'd0:    staged[7:0]  <= wdata;
               2'd1:    staged[15:8] <= wdata;
               2'd2:    div_q        <= commit_val[DIV_W-1:0];
               default: ;
            endcase
         end
         if (snap_en) snap_q <= div_wide;
      end
   end

   always_comb begin
      unique case (rd_sel)
         2'd0:    rdata = div_wide[7:0];
         2'd1:    rdata = snap_q[15:8];
         2'd2:    rdata = snap_q[23:16];
         default: rdata = '0;
      endcase
   end

   assign div_out = div_q;
endmodule

// File: rtl/serial_rx_regs.sv
`timescale 1ns/1ps
module serial_rx_regs
   import srx_regs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DIV_W      = 24,
   parameter int unsigned DIV_RESET  = 868,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_rd,
   input  logic              csr_wr,
   input  logic [7:0]        csr_wdata,
   output logic [7:0]        csr_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_err,
   output logic              rx_ready,
   output logic [DIV_W-1:0]  baud_div
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("serial_rx_regs: ADDR_W must be at least 3");
   end

   logic      hit_div;
   logic      hit_status;
   logic      hit_rxdata;
   logic      fifo_empty;
   logic      fifo_full;
   logic      fifo_push;
   logic      fifo_pop;
   rx_entry_t fifo_head;
   rx_entry_t rx_entry;
   logic [7:0] div_rdata;
   logic [7:0] status_byte;

   assign hit_div    = (csr_addr <= ADDR_W'(OFS_DIV_B2));
   assign hit_status = (csr_addr == ADDR_W'(OFS_STATUS));
   assign hit_rxdata = (csr_addr == ADDR_W'(OFS_RXDATA));

   assign rx_entry.data = rx_byte;
   assign rx_entry.err  = rx_err;
   assign fifo_push     = rx_valid && !fifo_full;
   assign fifo_pop      = csr_rd && hit_rxdata && !fifo_empty;
   assign rx_ready      = !fifo_full;

   srx_divisor #(
      .DIV_W     (DIV_W),
      .DIV_RESET (DIV_RESET)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (csr_wr && hit_div),
      .wr_sel  (csr_addr[1:0]),
      .wdata   (csr_wdata),
      .snap_en (csr_rd && (csr_addr == ADDR_W'(OFS_DIV_B0))),
      .rd_sel  (csr_addr[1:0]),
      .rdata   (div_rdata),
      .div_out (baud_div)
   );

   srx_fifo #(
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (fifo_push),
      .push_entry (rx_entry),
      .pop        (fifo_pop),
      .head       (fifo_head),
      .empty      (fifo_empty),
      .full       (fifo_full)
   );

   always_comb begin
      status_byte               = '0;
      status_byte[STS_NONEMPTY] = !fifo_empty;
      status_byte[STS_HEAD_ERR] = !fifo_empty && fifo_head.err;
   end

   always_comb begin
      if (hit_div)                       csr_rdata = div_rdata;
      else if (hit_status)               csr_rdata = status_byte;
      else if (hit_rxdata && !fifo_empty) csr_rdata = fifo_head.data;
      else                               csr_rdata = '0;
   end
endmodule

// File: rtl/srx_regs_chk.sv
`timescale 1ns/1ps
module srx_regs_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DIV_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] csr_addr,
   input logic              csr_rd,
   input logic              csr_wr,
   input logic [7:0]        csr_wdata,
   input logic [7:0]        csr_rdata,
   input logic              rx_ready,
   input logic [DIV_W-1:0]  baud_div,
   input logic              fifo_empty
);
   // R3
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_wr && csr_addr == ADDR_W'(2)) |=> $stable(baud_div));

   if (DIV_W > 16) begin : g_top_byte
      // R3
      div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (csr_wr && csr_addr == ADDR_W'(2)) |=>
            baud_div[DIV_W-1:16] == $past(csr_wdata[DIV_W-17:0]));
   end

   // R5
   status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr == ADDR_W'(3)) |->
         (csr_rdata[7:5] == 3'b000 && csr_rdata[3:1] == 3'b000));

   // R5
   status_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr == ADDR_W'(3) && fifo_empty) |-> csr_rdata == 8'h00);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr > ADDR_W'(4)) |-> csr_rdata == 8'h00);

   // R8
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr == ADDR_W'(4) && fifo_empty) |-> csr_rdata == 8'h00);

   // R7
   ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> rx_ready);
endmodule

bind serial_rx_regs srx_regs_chk #(
   .ADDR_W (ADDR_W),
   .DIV_W  (DIV_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csr_addr   (csr_addr),
   .csr_rd     (csr_rd),
   .csr_wr     (csr_wr),
   .csr_wdata  (csr_wdata),
   .csr_rdata  (csr_rdata),
   .rx_ready   (rx_ready),
   .baud_div   (baud_div),
   .fifo_empty (fifo_empty)
);

// File: tb/serial_rx_regs_tb.sv
`timescale 1ns/1ps
module serial_rx_regs_tb;
   localparam int unsigned DIV_RST = 868; // 0x000364

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] csr_addr = '0;
   logic       csr_rd = 1'b0;
   logic       csr_wr = 1'b0;
   logic [7:0] csr_wdata = '0;
   logic [7:0] csr_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_err = 1'b0;
   logic       rx_ready;
   logic [23:0] baud_div;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [8:0] exp_q [$];   // {err, byte} in arrival order

   always #2.5 clk = ~clk;

   serial_rx_regs #(.DIV_RESET(DIV_RST)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err),
      .rx_ready(rx_ready), .baud_div(baud_div)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      csr_addr = a; csr_rd = 1'b1;
      #1 d = csr_rdata;
      @(negedge clk);
      csr_rd = 1'b0;
   endtask

   // Driver: offer one byte; record it as expected only if the design takes it.
   task automatic rx_offer(input logic [7:0] b, input logic e, input logic exp_take, input string req);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b; rx_err = e;
      #1 check(req, rx_ready, exp_take);
      if (rx_ready) exp_q.push_back({e, b});
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // Monitor: read the data register and compare against the scoreboard.
   task automatic rx_collect(input string req);
      logic [7:0] d;
      logic [8:0] e;
      bus_rd(4'd4, d);
      if (exp_q.size() == 0) check(req, d, 8'h00);
      else begin
         e = exp_q.pop_front();
         check(req, d, e[7:0]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      check("R1 divisor", baud_div, DIV_RST);
      check("R1 ready", rx_ready, 1'b1);
      bus_rd(4'd3, d); check("R1 status", d, 8'h00);

      // R2 byte order, snapshot of reset value
      bus_rd(4'd0, d); check("R2 byte0", d, 8'h64);
      bus_rd(4'd1, d); check("R2 byte1", d, 8'h03);
      bus_rd(4'd2, d); check("R2 byte2", d, 8'h00);

      // R3 staging then commit
      bus_wr(4'd0, 8'hAB);
      bus_wr(4'd1, 8'hCD);
      check("R3 staged no change", baud_div, DIV_RST);
      bus_wr(4'd2, 8'h12);
      check("R3 commit", baud_div, 24'h12CDAB);

      // R4 snapshot survives a later commit
      bus_rd(4'd0, d); check("R4 live byte0", d, 8'hAB);
      bus_wr(4'd0, 8'h03);
      bus_wr(4'd1, 8'h02);
      bus_wr(4'd2, 8'h01);
      check("R3 second commit", baud_div, 24'h010203);
      bus_rd(4'd1, d); check("R4 snap byte1", d, 8'hCD);
      bus_rd(4'd2, d); check("R4 snap byte2", d, 8'h12);
      bus_rd(4'd0, d); check("R4 new byte0", d, 8'h03);
      bus_rd(4'd1, d); check("R4 new byte1", d, 8'h02);

      // R9 unmapped offsets
      bus_wr(4'd7, 8'hFF);
      bus_wr(4'd15, 8'hFF);
      bus_wr(4'd4, 8'hFF);
      bus_wr(4'd3, 8'hFF);
      bus_rd(4'd7, d);  check("R9 read 7", d, 8'h00);
      bus_rd(4'd15, d); check("R9 read 15", d, 8'h00);
      check("R9 divisor kept", baud_div, 24'h010203);
      bus_rd(4'd3, d);  check("R9 status kept", d, 8'h00);

      // R8 empty read returns zero and removes nothing
      rx_collect("R8 empty read");
      rx_offer(8'h5A, 1'b0, 1'b1, "R7 accept");
      rx_collect("R8 next byte after empty read");
      bus_rd(4'd3, d); check("R8 empty again", d, 8'h00);

      // R5 R6 status and pop order with error flags
      rx_offer(8'h41, 1'b0, 1'b1, "R7 accept");
      rx_offer(8'h42, 1'b1, 1'b1, "R7 accept");
      rx_offer(8'h43, 1'b0, 1'b1, "R7 accept");
      bus_rd(4'd3, d); check("R5 nonempty", d, 8'h01);
      rx_collect("R6 first");
      bus_rd(4'd3, d); check("R5 head error", d, 8'h11);
      rx_collect("R6 second");
      bus_rd(4'd3, d); check("R5 clean head", d, 8'h01);
      rx_collect("R6 third");
      bus_rd(4'd3, d); check("R5 drained", d, 8'h00);

      // R7 fill to sixteen, refuse the seventeenth, drain in order
      for (int i = 0; i < 16; i++)
         rx_offer(8'(8'h80 + i), 1'(i % 3 == 0), 1'b1, "R7 fill");
      #1 check("R7 full not ready", rx_ready, 1'b0);
      rx_offer(8'hEE, 1'b1, 1'b0, "R7 refuse when full");
      for (int i = 0; i < 16; i++) rx_collect("R7 drain order");
      rx_collect("R8 empty after drain");
      #1 check("R7 ready after drain", rx_ready, 1'b1);

      check("R3 divisor untouched by traffic", baud_div, 24'h010203);
      finish_run();
   end
endmodule